// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of an Ethernet controller's DMA path. Software places a ring of buffer descriptors in memory, points the engine at the ring start and writes an activation code to the poll register. The engine then reads the current descriptor. If software has marked it empty, the engine takes ownership and waits for a frame on its byte-stream input. Each byte is packed big-endian into 32-bit words that go into the descriptor's buffer. When the frame ends, the engine writes back the byte count and an error summary, and clears the empty flag to hand the descriptor back to software. It then moves on to the next descriptor, and the wrap flag of the last descriptor sends it back to the ring start.

A descriptor is two memory words. Word 0 carries the 16-bit status/control field in bits 31:16 and the 16-bit length in bits 15:0. Word 1 carries the buffer's byte address, whose low two bits are ignored. In the status field, bit 15 is the empty flag, bit 13 the wrap flag, bits 14:6 are software bits that pass through untouched, and bits 5:0 report errors.

If the engine finds a descriptor that software still owns, it stops polling. Any frame that arrives while the engine is not ready is discarded and raises a busy flag, which stays set until the next poll activation.

Top module: `rxbd_ring_engine`

## Requirements
- R1: After reset, no memory request is made, `rx_busy` and `rx_frame_done` are low, and no descriptor is read until a poll activation.
- R2: The engine starts polling only on a register write to address 3 with data exactly 0x01000000, and polling reads word 0 and then word 1 of the current descriptor. A write of any other value to address 3 causes no memory access.
- R3: The descriptor layout is: word 0 holds status in [31:16] and length in [15:0], word 1 holds the buffer byte address, status bit 15 is the empty flag and status bit 13 is the wrap flag.
- R4: If the fetched descriptor's empty flag is clear, polling stops. A frame that arrives while the engine holds no empty descriptor produces no memory write and sets `rx_busy`.
- R5: Frame bytes are stored big-endian: the first byte goes in bits 31:24 of the buffer's first word. A partial final word is written with byte enables 1000, 1100 or 1110, and memory beyond the frame is left unchanged.
- R6: The write-back stores the frame's full byte count (CRC included) in the length field. It clears the empty flag and keeps status bits 14:6 as fetched.
- R7: Status bits 5:0 are zero for a good frame. Bit 0 is set if `rx_err` was seen on any byte. Bit 1 is set if the count exceeds the buffer-size register (address 1, reset 1520), and bytes past that size are not written. Bit 5 is set if the count exceeds the maximum-frame register (address 2, reset 1518).
- R8: After a write-back the engine fetches the descriptor two words further on. If the completed descriptor had its wrap flag set, it fetches the ring start instead.
- R9: `rx_frame_done` is high for exactly one cycle, the cycle after the status write-back is on the memory port.
- R10: A poll activation clears `rx_busy`.
- R11: A write to the ring-start register (address 0, word address) moves the current descriptor pointer to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 ring start, 1 buffer size, 2 max frame, 3 poll |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 1 | Error marker on this byte |
| mem_req | output | 1 | Memory access request, accepted in the same cycle |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, bit 3 selects bits 31:24 |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_frame_done | output | 1 | One-cycle pulse after a descriptor write-back |
| rx_busy | output | 1 | A frame was dropped since the last poll |

## Verification
Word 0 is read one cycle after a poll write is sampled, and the engine is ready to take bytes four cycles after that write. The final buffer word is written one cycle after the last byte, the status word one cycle later, and `rx_frame_done` one cycle after the status word. The bench drives inputs on the falling edge and waits for the done pulse before reading memory. A monitor checks that the pulse falls exactly one cycle after the descriptor write. Busy and read-count checks are taken on the falling edge that follows the register write or the dropped frame, after a settling gap longer than the fetch latency.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int LEN_W = 16;
  localparam int EMPTY_BIT = 15;
  localparam int WRAP_BIT = 13;
  localparam logic [31:0] POLL_KEY = 32'h0100_0000;
  localparam logic [1:0] RA_BASE = 2'd0;
  localparam logic [1:0] RA_BUF  = 2'd1;
  localparam logic [1:0] RA_MAX  = 2'd2;
  localparam logic [1:0] RA_POLL = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_CHK, ST_READY, ST_RECV, ST_FLUSH, ST_WB
  } rx_state_e;
endpackage

// File: rtl/rxbd_cfg.sv
module rxbd_cfg
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUF_DEF = 1520,
  parameter int MAXLEN_DEF = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [LEN_W-1:0]  buf_lim_q,
  output logic [LEN_W-1:0]  max_len_q,
  output logic              base_ld_q,
  output logic              poll_p
);
  logic [ADDR_W-1:0] base_n;
  logic [LEN_W-1:0]  buf_n, max_n;
  logic              base_ld_n;

  always_comb begin
    base_n    = base_q;
    buf_n     = buf_lim_q;
    max_n     = max_len_q;
    base_ld_n = 1'b0;
    poll_p    = 1'b0;
    if (cfg_we) begin
      unique case (cfg_addr)
        RA_BASE: begin base_n = cfg_wdata[ADDR_W-1:0]; base_ld_n = 1'b1; end
        RA_BUF:  buf_n = cfg_wdata[LEN_W-1:0];
        RA_MAX:  max_n = cfg_wdata[LEN_W-1:0];
        default: poll_p = (cfg_wdata == POLL_KEY);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      buf_lim_q <= LEN_W'(BUF_DEF);
      max_len_q <= LEN_W'(MAXLEN_DEF);
      base_ld_q <= 1'b0;
    end else begin
      base_q    <= base_n;
      buf_lim_q <= buf_n;
      max_len_q <= max_n;
      base_ld_q <= base_ld_n;
    end
  end
endmodule

// File: rtl/rxbd_packer.sv
module rxbd_packer
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [7:0]        bdata,
  input  logic              blast,
  input  logic              berr,
  input  logic [ADDR_W-1:0] buf_word,
  input  logic [LEN_W-1:0]  buf_lim,
  output logic              wr_vld_q,
  output logic [ADDR_W-1:0] wr_addr_q,
  output logic [31:0]       wr_data_q,
  output logic [3:0]        wr_be_q,
  output logic [LEN_W-1:0]  cnt_q,
  output logic              err_q
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [31:0]       acc_d_q, acc_d_n, dat_ins, wr_data_n;
  logic [3:0]        acc_be_q, acc_be_n, be_ins, wr_be_n;
  logic [LEN_W-1:0]  cnt_n;
  logic [ADDR_W-1:0] wr_addr_n;
  logic [1:0]        lane;
  logic              keep, flush_now, wr_vld_n, err_n;

  assign lane = cnt_q[1:0];
  assign keep = (cnt_q < buf_lim);

  always_comb begin
    dat_ins = acc_d_q;
    for (int i = 0; i < 4; i++) begin
      if (lane == 2'(i) && keep) dat_ins[31-8*i -: 8] = bdata;
    end
    be_ins    = acc_be_q | (keep ? (4'b1000 >> lane) : 4'b0000);
    flush_now = take && ((lane == 2'd3) || blast);
  end

  always_comb begin
    acc_d_n   = acc_d_q;
    acc_be_n  = acc_be_q;
    cnt_n     = cnt_q;
    err_n     = err_q;
    wr_vld_n  = 1'b0;
    wr_data_n = wr_data_q;
    wr_be_n   = wr_be_q;
    wr_addr_n = wr_addr_q;
    if (clr) begin
      acc_d_n  = '0;
      acc_be_n = '0;
      cnt_n    = '0;
      err_n    = 1'b0;
    end else if (take) begin
      err_n = err_q | berr;
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
      if (flush_now) begin
        wr_vld_n  = (be_ins != 4'b0000);
        wr_data_n = dat_ins;
        wr_be_n   = be_ins;
        wr_addr_n = buf_word + ADDR_W'(cnt_q >> 2);
        acc_d_n   = '0;
        acc_be_n  = '0;
      end else begin
        acc_d_n  = dat_ins;
        acc_be_n = be_ins;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_d_q   <= '0;
      acc_be_q  <= '0;
      cnt_q     <= '0;
      err_q     <= 1'b0;
      wr_vld_q  <= 1'b0;
      wr_data_q <= '0;
      wr_be_q   <= '0;
      wr_addr_q <= '0;
    end else begin
      acc_d_q   <= acc_d_n;
      acc_be_q  <= acc_be_n;
      cnt_q     <= cnt_n;
      err_q     <= err_n;
      wr_vld_q  <= wr_vld_n;
      wr_data_q <= wr_data_n;
      wr_be_q   <= wr_be_n;
      wr_addr_q <= wr_addr_n;
    end
  end

  // R5
  be_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld_q |-> (wr_be_q == 4'b1000 || wr_be_q == 4'b1100 ||
                  wr_be_q == 4'b1110 || wr_be_q == 4'b1111));
endmodule

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_p,
  input  logic              base_ld,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [LEN_W-1:0]  buf_lim,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [31:0]       mem_rdata,
  input  logic [LEN_W-1:0]  byte_cnt,
  input  logic              err_seen,
  output logic              take,
  output logic              pk_clr,
  output logic [ADDR_W-1:0] buf_word,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [31:0]       wb_data,
  output logic              busy_q,
  output logic              done_q
);
  rx_state_e         state_q, state_n;
  logic [ADDR_W-1:0] cur_q, cur_n, ptr_q, ptr_n;
  logic [15:0]       st_q, st_n;
  logic              drop_q, drop_n, busy_n, done_n;
  logic              accept_st, drop_start;
  logic [5:0]        errs;

  assign accept_st  = (state_q == ST_READY) || (state_q == ST_RECV);
  assign take       = rx_valid && !drop_q && accept_st;
  assign drop_start = rx_valid && !drop_q && !accept_st;
  assign pk_clr     = (state_q == ST_CHK);
  assign buf_word   = ptr_q;
  assign rd_req     = (state_q == ST_RD0) || (state_q == ST_RD1);
  assign rd_addr    = (state_q == ST_RD0) ? cur_q : cur_q + ADDR_W'(1);
  assign wb_req     = (state_q == ST_WB);
  assign wb_addr    = cur_q;
  assign errs       = {(byte_cnt > max_len), 3'b000, (byte_cnt > buf_lim), err_seen};
  assign wb_data    = {1'b0, st_q[14:6], errs, byte_cnt};

  always_comb begin
    state_n = state_q;
    cur_n   = cur_q;
    ptr_n   = ptr_q;
    st_n    = st_q;
    done_n  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (poll_p) state_n = ST_RD0;
      ST_RD0:   state_n = ST_RD1;
      ST_RD1:   begin st_n = mem_rdata[31:16]; state_n = ST_CHK; end
      ST_CHK:   begin
        ptr_n   = mem_rdata[ADDR_W+1:2];
        state_n = st_q[EMPTY_BIT] ? ST_READY : ST_IDLE;
      end
      ST_READY: if (take) state_n = rx_last ? ST_FLUSH : ST_RECV;
      ST_RECV:  if (take && rx_last) state_n = ST_FLUSH;
      ST_FLUSH: state_n = ST_WB;
      default: begin
        done_n  = 1'b1;
        cur_n   = st_q[WRAP_BIT] ? base_q : cur_q + ADDR_W'(2);
        state_n = ST_RD0;
      end
    endcase
    if (base_ld) cur_n = base_q;
  end

  always_comb begin
    drop_n = drop_q;
    if (drop_start && !rx_last) drop_n = 1'b1;
    else if (drop_q && rx_valid && rx_last) drop_n = 1'b0;
    busy_n = drop_start ? 1'b1 : (poll_p ? 1'b0 : busy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      ptr_q   <= '0;
      st_q    <= '0;
      drop_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cur_q   <= cur_n;
      ptr_q   <= ptr_n;
      st_q    <= st_n;
      drop_q  <= drop_n;
      busy_q  <= busy_n;
      done_q  <= done_n;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10
  poll_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_p && !rx_valid) |=> !busy_q);
  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(rx_valid));
  // R4
  no_take_unowned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> st_q[EMPTY_BIT]);
endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUF_DEF = 1520,
  parameter int MAXLEN_DEF = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  output logic              rx_frame_done,
  output logic              rx_busy
);
  logic [ADDR_W-1:0] base_q, buf_word, rd_addr, wb_addr, pk_addr;
  logic [LEN_W-1:0]  buf_lim, max_len, byte_cnt;
  logic              base_ld, poll_p, take, pk_clr, rd_req, wb_req;
  logic              pk_vld, err_seen;
  logic [31:0]       wb_data, pk_data;
  logic [3:0]        pk_be;

  rxbd_cfg #(.ADDR_W(ADDR_W), .BUF_DEF(BUF_DEF), .MAXLEN_DEF(MAXLEN_DEF)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .base_q(base_q), .buf_lim_q(buf_lim),
    .max_len_q(max_len), .base_ld_q(base_ld), .poll_p(poll_p));

  rxbd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .poll_p(poll_p), .base_ld(base_ld),
    .base_q(base_q), .buf_lim(buf_lim), .max_len(max_len),
    .rx_valid(rx_valid), .rx_last(rx_last), .mem_rdata(mem_rdata),
    .byte_cnt(byte_cnt), .err_seen(err_seen), .take(take), .pk_clr(pk_clr),
    .buf_word(buf_word), .rd_req(rd_req), .rd_addr(rd_addr),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data),
    .busy_q(rx_busy), .done_q(rx_frame_done));

  rxbd_packer #(.ADDR_W(ADDR_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .take(take), .bdata(rx_data),
    .blast(rx_last), .berr(rx_err), .buf_word(buf_word), .buf_lim(buf_lim),
    .wr_vld_q(pk_vld), .wr_addr_q(pk_addr), .wr_data_q(pk_data),
    .wr_be_q(pk_be), .cnt_q(byte_cnt), .err_q(err_seen));

  always_comb begin
    mem_req   = rd_req || pk_vld || wb_req;
    mem_we    = pk_vld || wb_req;
    mem_addr  = rd_req ? rd_addr : (pk_vld ? pk_addr : wb_addr);
    mem_wdata = pk_vld ? pk_data : wb_data;
    mem_be    = rd_req ? 4'b0000 : (pk_vld ? pk_be : 4'b1111);
  end

  // R6
  one_port_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, pk_vld, wb_req}));
  // R6
  wb_owner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !mem_wdata[16+EMPTY_BIT]);
endmodule

// File: tb/rxbd_ring_engine_tb.sv
module rxbd_ring_engine_tb;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        rx_valid, rx_last, rx_err;
  logic [7:0]  rx_data;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        rx_frame_done, rx_busy;

  logic [31:0] mem [0:1023];
  logic        bd_we;
  logic [9:0]  bd_addr;
  logic [31:0] bd_data;

  int checks, errors, cyc, last_wb, wr_cnt, rd_cnt, last_rd;
  bit finished;

  rxbd_ring_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata), .rx_frame_done(rx_frame_done), .rx_busy(rx_busy));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (bd_we) mem[bd_addr] <= bd_data;
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (mem_req && mem_we) begin
        wr_cnt = wr_cnt + 1;
        if (mem_addr >= 16 && mem_addr < 22) last_wb = cyc;
      end
      if (mem_req && !mem_we) begin rd_cnt = rd_cnt + 1; last_rd = int'(mem_addr); end
      if (rx_frame_done) begin
        checks = checks + 1;
        if (cyc != last_wb + 1) begin
          errors = errors + 1;
          $display("FAIL R9 done cycle act=%0d exp=%0d", cyc, last_wb + 1);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk); bd_we = 1'b1; bd_addr = 10'(a); bd_data = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] fbyte(input int seed, input int k);
    return 8'((seed + 3 * k + 1) & 255);
  endfunction

  function automatic logic [31:0] exp_word(input int seed, input int n, input int j, input int lim);
    logic [31:0] w;
    for (int l = 0; l < 4; l++) begin
      int k = 4 * j + l;
      w[31-8*l -: 8] = (k < n && k < lim) ? fbyte(seed, k) : 8'hA5;
    end
    return w;
  endfunction

  task automatic send(input int n, input int seed, input int erri);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fbyte(seed, k);
      rx_last = (k == n - 1); rx_err = (k == erri);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!rx_frame_done && t < 100) begin @(negedge clk); t++; end
    chk("R9 done pulse seen", 32'(rx_frame_done), 32'd1);
    @(negedge clk);
    chk("R9 done one cycle", 32'(rx_frame_done), 32'd0);
  endtask

  task automatic arm(input int d);
    poke(16 + 2 * d, {(d == 2) ? 16'hA400 : 16'h8400, 16'h0000});
    for (int j = 0; j < 4; j++) poke(256 + 64 * d + j, 32'hA5A5A5A5);
  endtask

  task automatic frame(input int d, input int n, input int seed, input int erri,
                       input int lim, input logic [5:0] experr, input bit rearm);
    logic [15:0] st;
    send(n, seed, erri);
    wait_done();
    st = 16'h0400 | ((d == 2) ? 16'h2000 : 16'h0000) | {10'd0, experr};
    chk("R3 R6 R7 R8 status/length word", mem[16 + 2 * d], {st, 16'(n)});
    for (int j = 0; j <= (n + 3) / 4; j++)
      chk("R5 R7 buffer word", mem[256 + 64 * d + j], exp_word(seed, n, j, lim));
    if (rearm) arm(d);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    finished = 0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors = errors + 1;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, rd0, wr0;
    checks = 0; errors = 0; cyc = 0; last_wb = -10; wr_cnt = 0; rd_cnt = 0; last_rd = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_err = 1'b0;
    bd_we = 1'b0; bd_addr = '0; bd_data = '0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
    chk("R1 busy after reset", 32'(rx_busy), 32'd0);
    chk("R1 done after reset", 32'(rx_frame_done), 32'd0);

    for (int i = 0; i < 3; i++) begin
      arm(i);
      poke(17 + 2 * i, 32'h400 + 32'h100 * i);
    end
    cfg_wr(2'd0, 32'd16);
    repeat (5) @(negedge clk);
    chk("R1 no reads before poll", 32'(rd_cnt), 32'd0);
    cfg_wr(2'd3, 32'h0000_0001);
    repeat (10) @(negedge clk);
    chk("R2 wrong poll value no read", 32'(rd_cnt), 32'd0);
    cfg_wr(2'd3, 32'h0100_0000);
    repeat (6) @(negedge clk);
    chk("R2 poll reads two words", 32'(rd_cnt), 32'd2);
    chk("R2 second read is word 1", 32'(last_rd), 32'd17);

    d = 0;
    for (int n = 1; n <= 9; n++) begin
      frame(d, n, n * 16, -1, 1520, 6'h00, 1'b1);
      d = (d == 2) ? 0 : d + 1;
    end

    cfg_wr(2'd1, 32'd6);
    cfg_wr(2'd2, 32'd5);
    frame(0, 5, 200, -1, 6, 6'h00, 1'b1);
    frame(1, 6, 210, -1, 6, 6'h20, 1'b1);
    frame(2, 8, 220, 3, 6, 6'h23, 1'b1);

    poke(16, 32'h0400_0000);
    poke(18, 32'h0400_0000);
    poke(20, 32'h2400_0000);
    frame(0, 4, 230, -1, 6, 6'h00, 1'b0);
    repeat (6) @(negedge clk);
    cfg_wr(2'd0, 32'd16);
    wr0 = wr_cnt;
    send(3, 240, -1);
    repeat (10) @(negedge clk);
    chk("R4 busy after dropped frame", 32'(rx_busy), 32'd1);
    chk("R4 no write for dropped frame", 32'(wr_cnt), 32'(wr0));
    chk("R4 non-empty descriptor untouched", mem[18], 32'h0400_0000);
    arm(0);
    rd0 = rd_cnt;
    cfg_wr(2'd3, 32'h0100_0000);
    chk("R10 poll clears busy", 32'(rx_busy), 32'd0);
    repeat (6) @(negedge clk);
    chk("R11 poll fetch count", 32'(rd_cnt - rd0), 32'd2);
    chk("R11 fetch from reloaded start", 32'(last_rd), 32'd17);
    frame(0, 2, 250, -1, 6, 6'h00, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule